// File: doc/BRIEF.md
# Miss-Dependence Tracker

While the core runs ahead past a long-latency cache miss, this block records which register values depend on that miss. It keeps one poison flag for each physical register. Every instruction the core issues reads the flags of its two source tags. If the instruction is itself a missing load, or if either of its sources is poisoned, its result is classified as poisoned. Otherwise the result is clean. The destination flag is then written with that classification.

The same source check decides what the instruction may do. A memory instruction produces a prefetch request only when its address operands are clean. A branch whose condition operands are poisoned is left unresolved, so the core keeps following its predicted direction. A clean branch is resolved, and a misprediction raises a recovery request.

The classification is written one stage after issue. A forwarding path from that pending write lets the next instruction see the new flag at once. When the core leaves runahead and restores its checkpoint, all flags are wiped in that same cycle, including any write still pending.

Top module: `poison_track`

## Requirements
- R1: After reset every register's poison flag reads clean. With no valid issue, `inv_o`, `pf_en_o`, `br_resolve_o` and `br_recover_o` are all 0.
- R2: A valid issue with `miss_i`=1 while `ahead_i`=1 drives `inv_o`=1. While `ahead_i`=0, `miss_i` alone does not poison the result.
- R3: An issued instruction with at least one poisoned source tag drives `inv_o`=1. If it has `dst_wr_i`=1, its destination is poisoned.
- R4: An issued instruction that writes a clean result (`inv_o`=0, `dst_wr_i`=1) clears its destination's flag.
- R5: The instruction issued in the cycle right after a write sees that write's new flag value for a matching source tag.
- R6: `pf_en_o`=1 exactly when a valid issue has `is_mem_i`=1 and both source tags are clean.
- R7: A branch (`is_br_i`=1) with a poisoned source drives `br_resolve_o`=0 and `br_recover_o`=0.
- R8: A branch with clean sources drives `br_resolve_o`=1. It also drives `br_recover_o`=1 exactly when `br_pred_i` differs from `br_taken_i`.
- R9: In a cycle with `exit_i`=1, all flags are cleared, a pending write is dropped, and the issue port is ignored: all outputs read 0 and no flag is written.
- R10: An issued instruction with `dst_wr_i`=0 leaves every flag unchanged, whatever its own classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahead_i | input | 1 | Core is in runahead mode |
| exit_i | input | 1 | Runahead exit / checkpoint restore this cycle |
| iss_vld_i | input | 1 | An instruction issues this cycle |
| src_a_i | input | TAG_W | First source tag |
| src_b_i | input | TAG_W | Second source tag |
| dst_wr_i | input | 1 | Instruction writes a destination register |
| dst_i | input | TAG_W | Destination tag |
| miss_i | input | 1 | Instruction is a load that missed the last-level cache |
| is_mem_i | input | 1 | Instruction computes a memory address |
| is_br_i | input | 1 | Instruction is a conditional branch |
| br_pred_i | input | 1 | Predicted direction |
| br_taken_i | input | 1 | Computed direction |
| inv_o | output | 1 | Result of the issued instruction is poisoned |
| pf_en_o | output | 1 | Address may be used to issue a prefetch |
| br_resolve_o | output | 1 | Branch is resolved this cycle |
| br_recover_o | output | 1 | Resolved branch was mispredicted; start recovery |

## Verification
The hardest situation to reach is a wipe on runahead exit that coincides with a poisoned write still sitting in the write stage. It is also hard to see a flag being both written and read across the pending stage. The stimulus issues a poisoning instruction immediately before the exit cycle. It then issues an ignored instruction during the exit cycle and reads the same tags right afterwards. Back-to-back dependent instructions in the vector table cover forwarding of both a poisoning write and a clearing write.

// File: rtl/poison_pkg.sv
package poison_pkg;
  typedef struct packed {
    logic resolve;
    logic recover;
  } br_verdict_t;

  function automatic br_verdict_t judge_branch(input logic is_br, input logic src_bad,
                                               input logic pred, input logic taken);
    br_verdict_t v;
    v.resolve = is_br & ~src_bad;
    v.recover = is_br & ~src_bad & (pred ^ taken);
    return v;
  endfunction
endpackage

// File: rtl/poison_bits.sv
module poison_bits #(
  parameter int unsigned NREGS = 64,
  localparam int unsigned TAG_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_inv_i,
  input  logic [TAG_W-1:0] rd_a_tag_i,
  input  logic [TAG_W-1:0] rd_b_tag_i,
  output logic             rd_a_inv_o,
  output logic             rd_b_inv_o
);
  logic [NREGS-1:0] bits_q, bits_d;
  logic             wb_vld_q, wb_vld_d;
  logic [TAG_W-1:0] wb_tag_q;
  logic             wb_inv_q;

  always_comb begin
    bits_d = bits_q;
    if (clr_i) bits_d = '0;
    else if (wb_vld_q) bits_d[wb_tag_q] = wb_inv_q;
    wb_vld_d = wr_en_i & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q   <= '0;
      wb_vld_q <= 1'b0;
    end else begin
      bits_q   <= bits_d;
      wb_vld_q <= wb_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_tag_q <= '0;
      wb_inv_q <= 1'b0;
    end else if (wb_vld_d) begin
      wb_tag_q <= wr_tag_i;
      wb_inv_q <= wr_inv_i;
    end
  end

  always_comb begin
    rd_a_inv_o = (wb_vld_q && wb_tag_q == rd_a_tag_i) ? wb_inv_q : bits_q[rd_a_tag_i];
    rd_b_inv_o = (wb_vld_q && wb_tag_q == rd_b_tag_i) ? wb_inv_q : bits_q[rd_b_tag_i];
  end

  assert_clear_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (bits_q == '0 && !wb_vld_q));

  assert_valid_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld_q && !wb_inv_q && !clr_i) |=> !bits_q[$past(wb_tag_q)]);
endmodule

// File: rtl/poison_gate.sv
module poison_gate
  import poison_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic src_bad_i,
  input  logic is_mem_i,
  input  logic is_br_i,
  input  logic pred_i,
  input  logic taken_i,
  output logic pf_en_o,
  output logic resolve_o,
  output logic recover_o
);
  br_verdict_t verdict;

  always_comb begin
    verdict   = judge_branch(vld_i & is_br_i, src_bad_i, pred_i, taken_i);
    pf_en_o   = vld_i & is_mem_i & ~src_bad_i;
    resolve_o = verdict.resolve;
    recover_o = verdict.recover;
  end

  assert_recover_needs_resolve_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recover_o |-> (resolve_o && (pred_i != taken_i)));
endmodule

// File: rtl/poison_track.sv
module poison_track #(
  parameter int unsigned NREGS = 64,
  localparam int unsigned TAG_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ahead_i,
  input  logic             exit_i,
  input  logic             iss_vld_i,
  input  logic [TAG_W-1:0] src_a_i,
  input  logic [TAG_W-1:0] src_b_i,
  input  logic             dst_wr_i,
  input  logic [TAG_W-1:0] dst_i,
  input  logic             miss_i,
  input  logic             is_mem_i,
  input  logic             is_br_i,
  input  logic             br_pred_i,
  input  logic             br_taken_i,
  output logic             inv_o,
  output logic             pf_en_o,
  output logic             br_resolve_o,
  output logic             br_recover_o
);
  logic vld, a_bad, b_bad, src_bad, res_inv;

  always_comb begin
    vld     = iss_vld_i & ~exit_i;
    src_bad = a_bad | b_bad;
    res_inv = vld & ((ahead_i & miss_i) | src_bad);
    inv_o   = res_inv;
  end

  poison_bits #(.NREGS(NREGS)) u_bits (
    .clk(clk), .rst_n(rst_n), .clr_i(exit_i),
    .wr_en_i(vld & dst_wr_i), .wr_tag_i(dst_i), .wr_inv_i(res_inv),
    .rd_a_tag_i(src_a_i), .rd_b_tag_i(src_b_i),
    .rd_a_inv_o(a_bad), .rd_b_inv_o(b_bad)
  );

  poison_gate u_gate (
    .clk(clk), .rst_n(rst_n), .vld_i(vld), .src_bad_i(src_bad),
    .is_mem_i(is_mem_i), .is_br_i(is_br_i), .pred_i(br_pred_i), .taken_i(br_taken_i),
    .pf_en_o(pf_en_o), .resolve_o(br_resolve_o), .recover_o(br_recover_o)
  );

  assert_inv_branch_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_resolve_o |-> !(a_bad || b_bad));

  assert_pf_needs_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_en_o && !(ahead_i && miss_i)) |-> !inv_o);

  assert_miss_poisons_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld_i && !exit_i && ahead_i && miss_i) |-> inv_o);

  assert_exit_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exit_i |-> !(inv_o || pf_en_o || br_resolve_o || br_recover_o));
endmodule

// File: tb/poison_track_tb.sv
module poison_track_tb;
  localparam int NREGS = 64;
  localparam int TW = $clog2(NREGS);

  typedef struct packed {
    logic ah; logic [TW-1:0] sa; logic [TW-1:0] sb; logic wr; logic [TW-1:0] dst;
    logic miss; logic mem; logic br; logic pred; logic act;
    logic e_inv; logic e_pf; logic e_res; logic e_rec;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b0,6'd1,6'd1,1'b1,6'd3,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0},
    '{1'b1,6'd1,6'd1,1'b1,6'd5,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0},
    '{1'b1,6'd5,6'd2,1'b1,6'd6,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,6'd6,6'd6,1'b1,6'd7,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,6'd7,6'd0,1'b0,6'd0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,6'd2,6'd3,1'b0,6'd0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b1,6'd0,6'd3,1'b0,6'd0,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0},
    '{1'b1,6'd2,6'd2,1'b1,6'd6,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,6'd6,6'd6,1'b0,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0},
    '{1'b1,6'd8,6'd8,1'b1,6'd5,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,6'd5,6'd7,1'b0,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,6'd5,6'd5,1'b0,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}
  };
  // R2 vec0/1, R3 vec2/3/10, R4 vec7/9, R5 vec2/8, R6 vec1/3/8/11, R7 vec4, R8 vec5/6, R10 vec4->6

  logic clk = 1'b0, rst_n;
  logic ahead, ex, vld, dwr, miss, mem, br, pred, act;
  logic [TW-1:0] sa, sb, dst;
  logic inv, pf, res, rec;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  poison_track #(.NREGS(NREGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ahead_i(ahead), .exit_i(ex), .iss_vld_i(vld),
    .src_a_i(sa), .src_b_i(sb), .dst_wr_i(dwr), .dst_i(dst), .miss_i(miss),
    .is_mem_i(mem), .is_br_i(br), .br_pred_i(pred), .br_taken_i(act),
    .inv_o(inv), .pf_en_o(pf), .br_resolve_o(res), .br_recover_o(rec)
  );

  task automatic drive(input vec_t v, input logic e, input logic valid);
    @(negedge clk);
    ahead = v.ah; ex = e; vld = valid; sa = v.sa; sb = v.sb; dwr = v.wr; dst = v.dst;
    miss = v.miss; mem = v.mem; br = v.br; pred = v.pred; act = v.act;
    #5;
  endtask

  task automatic check(input string req, input vec_t v);
    checks++;
    if ({inv, pf, res, rec} !== {v.e_inv, v.e_pf, v.e_res, v.e_rec}) begin
      errors++;
      $display("FAIL %s: got inv/pf/res/rec=%b expected %b", req,
               {inv, pf, res, rec}, {v.e_inv, v.e_pf, v.e_res, v.e_rec});
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0;
    ahead = 0; ex = 0; vld = 0; sa = 0; sb = 0; dwr = 0; dst = 0;
    miss = 0; mem = 0; br = 0; pred = 0; act = 0;
    repeat (3) @(negedge clk);
    #5;
    v = '0;
    check("R1 idle outputs in reset", v);
    @(negedge clk) rst_n = 1'b1;

    // R1: every flag clean after reset
    v = '{1'b1,6'd0,6'd63,1'b0,6'd0,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0};
    drive(v, 1'b0, 1'b1); check("R1 flags clean after reset", v);

    for (int i = 0; i < 12; i++) begin
      drive(TBL[i], 1'b0, 1'b1);
      check($sformatf("R2-R10 vector %0d", i), TBL[i]);
    end

    // R9: poison reg 10 right before exit so its write is still pending
    v = '{1'b1,6'd7,6'd7,1'b1,6'd10,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0};
    drive(v, 1'b0, 1'b1); check("R3 poison reg 10", v);
    v = '{1'b1,6'd10,6'd10,1'b1,6'd9,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0};
    drive(v, 1'b1, 1'b1); check("R9 issue ignored in exit cycle", v);
    v = '{1'b0,6'd10,6'd7,1'b0,6'd0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0};
    drive(v, 1'b0, 1'b1); check("R9 pending and stored flags wiped", v);
    v = '{1'b0,6'd9,6'd9,1'b0,6'd0,1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1,1'b1};
    drive(v, 1'b0, 1'b1); check("R9 no write from exit cycle", v);

    // R1: no valid issue keeps outputs low even with poisoned-looking inputs
    v = '{1'b1,6'd0,6'd0,1'b0,6'd0,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0};
    drive(v, 1'b0, 1'b0); check("R1 outputs low without issue", v);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule